// File: doc/BRIEF.md
# Byte-Wide Configuration Stream Loader

This block accepts a configuration stream one byte per clock and unpacks it into payload writes for a configuration memory that sits outside the block. A stream opens with a fixed seven-byte header. A fixed number of frames follows. Each frame is a start marker, a fixed count of payload bytes and a closing check marker. Each payload byte leaves the block on a registered write port, tagged with its frame number and its position in the frame. If any marker does not match, the loader halts and pulls its active-low error line low. Only a low pulse on the program input clears the halt.

Loaders can be chained on one shared byte bus. While the header is loading, each loader passes its own select straight through to the next loader. Every loader in the chain therefore checks the same header on the same clock edges. After the header, the select passed onward is the loader's own registered fill-complete flag. Each loader takes its own frames and then hands the bus on. Once its frames are in, a loader counts a fixed number of start-up clocks, ignoring all bytes, and then raises done.

Top module: `cfg_stream_loader`

## Requirements
- R1: While `prog_n` is low and right after it rises: `init_n_o` is 1, and `done_o`, `fill_o` and `wr_en_o` are 0.
- R2: Bit k of `byte_i` is data line Dk, with D0 as the first bit. In this encoding the header is 0xFF, 0xFF, preamble 0x4F, 0xFF, 0xFF, 0xFF, header check 0x4B. A byte counts only on a clock edge where `cs_i` is 1.
- R3: A header byte that differs from its expected value, including a fill byte other than 0xFF, halts the loader. `init_n_o` is 0 after that edge and stays 0 until `prog_n` goes low. While halted there are no writes, and `fill_o` and `done_o` stay 0.
- R4: A frame is start byte 0x7F, then FRAME_BYTES payload bytes, then check byte 0x4B. Clock edges with `cs_i` low consume nothing.
- R5: After each edge that takes a payload byte, `wr_en_o` is 1 for one cycle. `wr_data_o` carries the byte, `wr_frame_o` the 0-based frame number and `wr_idx_o` the 0-based position in the frame. Payload values equal to marker values are written as plain data.
- R6: A start byte other than 0x7F, or a check byte other than 0x4B, halts the loader in the same way as R3. The MSB-first readings 0xFE and 0xD2 are both mismatches.
- R7: `fill_o` goes to 1 right after the edge that takes the check byte of frame NUM_FRAMES-1. It stays 1 until `prog_n` goes low.
- R8: `chain_cs_o` equals `cs_i` while the header is loading. After the header it equals `fill_o`.
- R9: `done_o` goes to 1 exactly STARTUP_CLKS clock edges after the edge that sets `fill_o`. Bytes during those clocks, whatever their value, cause no write and no error.
- R10: Once `done_o` is 1, it stays 1 and further bytes are ignored.
- R11: A low pulse on `prog_n` after a halt or after done starts a fresh load that behaves like the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, one byte per rising edge |
| prog_n | input | 1 | Active-low program pulse, asynchronous reset |
| cs_i | input | 1 | Chip-select; bytes are taken only while high |
| byte_i | input | 8 | Stream byte, bit k = Dk |
| wr_en_o | output | 1 | Payload write strobe |
| wr_frame_o | output | FR_W | Frame number of the write |
| wr_idx_o | output | IX_W | Byte position within the frame |
| wr_data_o | output | 8 | Payload byte |
| fill_o | output | 1 | All own frames received |
| chain_cs_o | output | 1 | Select for the next loader in the chain |
| init_n_o | output | 1 | Active-low error line |
| done_o | output | 1 | Start-up complete |

## Verification
On every cycle the assertions check these properties: a halt and a fill are sticky, no write appears while halted or after done, each write follows an edge with select high, write indices stay in range, done implies fill, and fill drives the onward select. Other behaviour can only be shown by the bench's scenarios. These are the exact header and marker encodings and the bit order, the payload landing at the right frame and index in both loaders of a two-loader chain, select stalls that consume nothing, the handover edge, and the exact start-up delay before done. The same holds for rejection of corrupted fill, preamble, start and check bytes, and for recovery through a program pulse.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;

    // Marker values as seen on byte_i[7:0] with byte_i[k] = Dk.
    localparam logic [7:0] MK_FILL  = 8'hFF;
    localparam logic [7:0] MK_PRE   = 8'h4F;
    localparam logic [7:0] MK_CHECK = 8'h4B;
    localparam logic [7:0] MK_START = 8'h7F;

    localparam int unsigned HDR_BYTES = 7;
    localparam logic [2:0]  HDR_LAST  = 3'(HDR_BYTES - 1);

    typedef enum logic [2:0] {
        ST_HDR,
        ST_SOF,
        ST_PAY,
        ST_EOF,
        ST_WARM,
        ST_DONE,
        ST_HALT
    } ldr_state_e;

    function automatic logic [7:0] hdr_expect(input logic [2:0] pos);
        case (pos)
            3'd2:    return MK_PRE;
            3'd6:    return MK_CHECK;
            default: return MK_FILL;
        endcase
    endfunction

endpackage

// File: rtl/cfg_ldr_hdr_match.sv
module cfg_ldr_hdr_match
    import cfg_ldr_pkg::*;
(
    input  logic [2:0] pos_i,
    input  logic [7:0] byte_i,
    output logic       match_o,
    output logic       last_o
);
    always_comb begin
        match_o = (byte_i == hdr_expect(pos_i));
        last_o  = (pos_i == HDR_LAST);
    end
endmodule

// File: rtl/cfg_ldr_warmup.sv
module cfg_ldr_warmup #(
    parameter int unsigned CLKS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic fin_o
);
    localparam int unsigned CNT_W = $clog2(CLKS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLKS - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run_i ? cnt_q + CNT_ONE : '0;
        fin_o = run_i && (cnt_q == CNT_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cfg_ldr_wr_port.sv
module cfg_ldr_wr_port #(
    parameter int unsigned FR_W = 2,
    parameter int unsigned IX_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_i,
    input  logic [FR_W-1:0] frame_i,
    input  logic [IX_W-1:0] idx_i,
    input  logic [7:0]      data_i,
    output logic            wr_en_o,
    output logic [FR_W-1:0] wr_frame_o,
    output logic [IX_W-1:0] wr_idx_o,
    output logic [7:0]      wr_data_o
);
    typedef struct packed {
        logic            en;
        logic [FR_W-1:0] frame;
        logic [IX_W-1:0] idx;
        logic [7:0]      data;
    } wr_t;

    wr_t wr_d, wr_q;

    always_comb begin
        wr_d    = wr_q;
        wr_d.en = take_i;
        if (take_i) begin
            wr_d.frame = frame_i;
            wr_d.idx   = idx_i;
            wr_d.data  = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= wr_d;
    end

    assign wr_en_o    = wr_q.en;
    assign wr_frame_o = wr_q.frame;
    assign wr_idx_o   = wr_q.idx;
    assign wr_data_o  = wr_q.data;
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
    import cfg_ldr_pkg::*;
#(
    parameter int unsigned FRAME_BYTES  = 4,
    parameter int unsigned NUM_FRAMES   = 3,
    parameter int unsigned STARTUP_CLKS = 6,
    localparam int unsigned IX_W = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1,
    localparam int unsigned FR_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic            clk,
    input  logic            prog_n,
    input  logic            cs_i,
    input  logic [7:0]      byte_i,
    output logic            wr_en_o,
    output logic [FR_W-1:0] wr_frame_o,
    output logic [IX_W-1:0] wr_idx_o,
    output logic [7:0]      wr_data_o,
    output logic            fill_o,
    output logic            chain_cs_o,
    output logic            init_n_o,
    output logic            done_o
);
    localparam logic [IX_W-1:0] IX_LAST = IX_W'(FRAME_BYTES - 1);
    localparam logic [FR_W-1:0] FR_LAST = FR_W'(NUM_FRAMES - 1);
    localparam logic [IX_W-1:0] IX_ONE  = IX_W'(1);
    localparam logic [FR_W-1:0] FR_ONE  = FR_W'(1);

    typedef struct packed {
        ldr_state_e      st;
        logic [2:0]      hpos;
        logic [FR_W-1:0] frame;
        logic [IX_W-1:0] idx;
        logic            fill;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic hdr_ok, hdr_last, warm_fin, take_pay;

    cfg_ldr_hdr_match u_hdr (
        .pos_i   (ctl_q.hpos),
        .byte_i  (byte_i),
        .match_o (hdr_ok),
        .last_o  (hdr_last)
    );

    cfg_ldr_warmup #(.CLKS(STARTUP_CLKS)) u_warm (
        .clk   (clk),
        .rst_n (prog_n),
        .run_i (ctl_q.st == ST_WARM),
        .fin_o (warm_fin)
    );

    cfg_ldr_wr_port #(.FR_W(FR_W), .IX_W(IX_W)) u_wr (
        .clk        (clk),
        .rst_n      (prog_n),
        .take_i     (take_pay),
        .frame_i    (ctl_q.frame),
        .idx_i      (ctl_q.idx),
        .data_i     (byte_i),
        .wr_en_o    (wr_en_o),
        .wr_frame_o (wr_frame_o),
        .wr_idx_o   (wr_idx_o),
        .wr_data_o  (wr_data_o)
    );

    always_comb begin
        ctl_d    = ctl_q;
        take_pay = 1'b0;
        case (ctl_q.st)
            ST_HDR: if (cs_i) begin
                if (!hdr_ok)       ctl_d.st = ST_HALT;
                else if (hdr_last) ctl_d.st = ST_SOF;
                else               ctl_d.hpos = ctl_q.hpos + 3'd1;
            end
            ST_SOF: if (cs_i) begin
                if (byte_i == MK_START) begin
                    ctl_d.st  = ST_PAY;
                    ctl_d.idx = '0;
                end else begin
                    ctl_d.st = ST_HALT;
                end
            end
            ST_PAY: if (cs_i) begin
                take_pay = 1'b1;
                if (ctl_q.idx == IX_LAST) ctl_d.st  = ST_EOF;
                else                      ctl_d.idx = ctl_q.idx + IX_ONE;
            end
            ST_EOF: if (cs_i) begin
                if (byte_i != MK_CHECK) begin
                    ctl_d.st = ST_HALT;
                end else if (ctl_q.frame == FR_LAST) begin
                    ctl_d.st   = ST_WARM;
                    ctl_d.fill = 1'b1;
                end else begin
                    ctl_d.frame = ctl_q.frame + FR_ONE;
                    ctl_d.st    = ST_SOF;
                end
            end
            ST_WARM: if (warm_fin) ctl_d.st = ST_DONE;
            default: ctl_d = ctl_q;
        endcase
    end

    always_ff @(posedge clk or negedge prog_n) begin
        if (!prog_n) begin
            ctl_q       <= '0;
            ctl_q.st    <= ST_HDR;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign fill_o     = ctl_q.fill;
    assign chain_cs_o = (ctl_q.st == ST_HDR) ? cs_i : ctl_q.fill;
    assign init_n_o   = (ctl_q.st != ST_HALT);
    assign done_o     = (ctl_q.st == ST_DONE);
endmodule

// File: rtl/cfg_stream_loader_chk.sv
module cfg_stream_loader_chk #(
    parameter int unsigned FRAME_BYTES = 4,
    parameter int unsigned NUM_FRAMES  = 3,
    parameter int unsigned IX_W        = 2,
    parameter int unsigned FR_W        = 2
) (
    input logic            clk,
    input logic            prog_n,
    input logic            cs_i,
    input logic            wr_en_o,
    input logic [FR_W-1:0] wr_frame_o,
    input logic [IX_W-1:0] wr_idx_o,
    input logic            fill_o,
    input logic            chain_cs_o,
    input logic            init_n_o,
    input logic            done_o
);
    assert_halt_sticky_R3: assert property (@(posedge clk) disable iff (!prog_n)
        !init_n_o |=> !init_n_o);

    assert_no_write_halted_R6: assert property (@(posedge clk) disable iff (!prog_n)
        !init_n_o |-> !wr_en_o);

    assert_write_needs_cs_R4: assert property (@(posedge clk) disable iff (!prog_n)
        wr_en_o |-> $past(cs_i));

    assert_index_range_R5: assert property (@(posedge clk) disable iff (!prog_n)
        wr_en_o |-> (32'(wr_idx_o) < FRAME_BYTES) && (32'(wr_frame_o) < NUM_FRAMES));

    assert_fill_sticky_R7: assert property (@(posedge clk) disable iff (!prog_n)
        fill_o |=> fill_o);

    assert_handover_R8: assert property (@(posedge clk) disable iff (!prog_n)
        fill_o |-> chain_cs_o);

    assert_done_after_fill_R9: assert property (@(posedge clk) disable iff (!prog_n)
        done_o |-> fill_o);

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!prog_n)
        done_o |=> done_o && !wr_en_o);
endmodule

bind cfg_stream_loader cfg_stream_loader_chk #(
    .FRAME_BYTES (FRAME_BYTES),
    .NUM_FRAMES  (NUM_FRAMES),
    .IX_W        (IX_W),
    .FR_W        (FR_W)
) u_chk (
    .clk        (clk),
    .prog_n     (prog_n),
    .cs_i       (cs_i),
    .wr_en_o    (wr_en_o),
    .wr_frame_o (wr_frame_o),
    .wr_idx_o   (wr_idx_o),
    .fill_o     (fill_o),
    .chain_cs_o (chain_cs_o),
    .init_n_o   (init_n_o),
    .done_o     (done_o)
);

// File: tb/tb_cfg_stream_loader.sv
module tb_cfg_stream_loader;
    localparam int FB = 3;
    localparam int NF = 2;
    localparam int SU = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       prog_n, cs0;
    logic [7:0] byte_r;

    logic       wr_en0, fill0, chain01, init_n0, done0;
    logic [0:0] wr_fr0;
    logic [1:0] wr_ix0;
    logic [7:0] wr_d0;
    logic       wr_en1, fill1, chain1x, init_n1, done1;
    logic [0:0] wr_fr1;
    logic [1:0] wr_ix1;
    logic [7:0] wr_d1;

    cfg_stream_loader #(.FRAME_BYTES(FB), .NUM_FRAMES(NF), .STARTUP_CLKS(SU)) dut (
        .clk(clk), .prog_n(prog_n), .cs_i(cs0), .byte_i(byte_r),
        .wr_en_o(wr_en0), .wr_frame_o(wr_fr0), .wr_idx_o(wr_ix0), .wr_data_o(wr_d0),
        .fill_o(fill0), .chain_cs_o(chain01), .init_n_o(init_n0), .done_o(done0));

    cfg_stream_loader #(.FRAME_BYTES(FB), .NUM_FRAMES(NF), .STARTUP_CLKS(SU)) dut2 (
        .clk(clk), .prog_n(prog_n), .cs_i(chain01), .byte_i(byte_r),
        .wr_en_o(wr_en1), .wr_frame_o(wr_fr1), .wr_idx_o(wr_ix1), .wr_data_o(wr_d1),
        .fill_o(fill1), .chain_cs_o(chain1x), .init_n_o(init_n1), .done_o(done1));

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard: expected writes, encoded frame*65536 + idx*256 + data.
    int q0[$];
    int q1[$];

    always @(negedge clk) begin
        int a0, e0;
        if (prog_n && wr_en0) begin
            a0 = int'(wr_fr0) * 65536 + int'(wr_ix0) * 256 + int'(wr_d0);
            if (q0.size() == 0) chk(1'b0, "R5 dut unexpected write", a0, -1);
            else begin
                e0 = q0.pop_front();
                chk(a0 == e0, "R5 dut write", a0, e0);
            end
        end
    end

    always @(negedge clk) begin
        int a1, e1;
        if (prog_n && wr_en1) begin
            a1 = int'(wr_fr1) * 65536 + int'(wr_ix1) * 256 + int'(wr_d1);
            if (q1.size() == 0) chk(1'b0, "R5 dut2 unexpected write", a1, -1);
            else begin
                e1 = q1.pop_front();
                chk(a1 == e1, "R5 dut2 write", a1, e1);
            end
        end
    end

    // Start-up delay monitor (R9)
    int  tf0, tf1;
    bit  pf0, pd0, pf1, pd1;
    always @(negedge clk) begin
        if (!prog_n) begin
            pf0 = 0; pd0 = 0; pf1 = 0; pd1 = 0; tf0 = 0; tf1 = 0;
        end else begin
            if (fill0 && !pf0) tf0 = cyc;
            if (fill1 && !pf1) tf1 = cyc;
            if (done0 && !pd0) chk(cyc - tf0 == SU, "R9 dut start-up delay", cyc - tf0, SU);
            if (done1 && !pd1) chk(cyc - tf1 == SU, "R9 dut2 start-up delay", cyc - tf1, SU);
            pf0 = fill0; pd0 = done0; pf1 = fill1; pd1 = done1;
        end
    end

    function automatic logic [7:0] pat(input int dev, input int f, input int i);
        if (dev == 0 && f == 1 && i == 0) return 8'h4B;
        if (dev == 1 && f == 0 && i == 2) return 8'h7F;
        return 8'(dev * 64 + f * 16 + i * 5 + 1);
    endfunction

    task automatic send(input logic [7:0] b);
        byte_r = b;
        @(negedge clk);
    endtask

    task automatic do_reset();
        prog_n = 1'b0; cs0 = 1'b0; byte_r = 8'h00;
        repeat (2) @(negedge clk);
        q0.delete(); q1.delete();
        prog_n = 1'b1;
    endtask

    task automatic send_hdr();
        send(8'hFF); send(8'hFF); send(8'h4F);
        send(8'hFF); send(8'hFF); send(8'hFF); send(8'h4B);
    endtask

    task automatic send_frame(input int dev, input int f, input bit stall);
        send(8'h7F);
        for (int i = 0; i < FB; i++) begin
            if (dev == 0) q0.push_back(f * 65536 + i * 256 + int'(pat(dev, f, i)));
            else          q1.push_back(f * 65536 + i * 256 + int'(pat(dev, f, i)));
            send(pat(dev, f, i));
            if (stall && i == 0) begin
                cs0 = 1'b0;
                send(8'h00);
                send(8'h4B);
                cs0 = 1'b1;
            end
        end
        send(8'h4B);
    endtask

    task automatic full_load(input string tag);
        cs0 = 1'b1;
        send(8'hFF);
        chk(chain01 == cs0, {tag, " R8 select passes during header"}, int'(chain01), 1);
        send(8'hFF); send(8'h4F); send(8'hFF); send(8'hFF); send(8'hFF); send(8'h4B);
        chk(chain01 == 1'b0, {tag, " R8 select after header"}, int'(chain01), 0);
        chk(init_n0 && init_n1, {tag, " R2 header accepted"}, int'(init_n0 & init_n1), 1);
        send_frame(0, 0, 1'b1);
        send_frame(0, 1, 1'b0);
        chk(fill0 == 1'b1, {tag, " R7 dut fill after last check"}, int'(fill0), 1);
        chk(fill1 == 1'b0, {tag, " R7 dut2 not yet filled"}, int'(fill1), 0);
        chk(chain01 == 1'b1, {tag, " R8 handover"}, int'(chain01), 1);
        send_frame(1, 0, 1'b0);
        send_frame(1, 1, 1'b0);
        chk(fill1 == 1'b1, {tag, " R7 dut2 fill"}, int'(fill1), 1);
        chk(init_n0 == 1'b1, {tag, " R9 start-up bytes ignored"}, int'(init_n0), 1);
        repeat (SU + 2) send(8'hFF);
        chk(done0 && done1, {tag, " R9 both done"}, int'(done0) * 2 + int'(done1), 3);
        chk(q0.size() == 0 && q1.size() == 0, {tag, " R5 all writes seen"},
            q0.size() + q1.size(), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        prog_n = 1'b0; cs0 = 1'b0; byte_r = 8'h00;
        @(negedge clk);
        chk(init_n0 && !done0 && !fill0 && !wr_en0, "R1 reset state dut", int'(init_n0), 1);
        do_reset();
        chk(init_n1 && !done1 && !fill1 && !wr_en1, "R1 reset state dut2", int'(init_n1), 1);

        // Chain load with a select stall inside the first frame
        full_load("A");

        // R10: bytes after done are ignored
        send(8'h00); send(8'h7F); send(8'h12); send(8'h4B);
        chk(done0 && done1, "R10 done holds", int'(done0 & done1), 1);
        chk(init_n0 && init_n1, "R10 no error after done", int'(init_n0 & init_n1), 1);

        // R3: bad fill byte in header
        do_reset(); cs0 = 1'b1;
        send(8'hFF); send(8'hFF); send(8'h4F); send(8'hFE);
        chk(init_n0 == 1'b0, "R3 bad fill byte halts", int'(init_n0), 0);
        send(8'h4B); send(8'h7F); send(8'h01); send(8'h02); send(8'h03); send(8'h4B);
        repeat (SU + 2) send(8'hFF);
        chk(!init_n0 && !fill0 && !done0, "R3 halt holds", int'(init_n0), 0);

        // R3: bad preamble (MSB-first reading)
        do_reset(); cs0 = 1'b1;
        send(8'hFF); send(8'hFF); send(8'hF2);
        chk(init_n0 == 1'b0 && init_n1 == 1'b0, "R3 bad preamble halts chain",
            int'(init_n0) + int'(init_n1), 0);

        // R6: bad check byte in a frame
        do_reset(); cs0 = 1'b1;
        send_hdr();
        send(8'h7F);
        for (int i = 0; i < FB; i++) begin
            q0.push_back(i * 256 + 8'h20 + i);
            send(8'(8'h20 + i));
        end
        send(8'hD2);
        chk(init_n0 == 1'b0, "R6 bad check byte halts", int'(init_n0), 0);
        chk(init_n1 == 1'b1, "R6 unselected loader unaffected", int'(init_n1), 1);
        repeat (SU + 2) send(8'h4B);
        chk(!fill0 && !done0 && q0.size() == 0, "R6 no fill after halt", int'(fill0), 0);

        // R6: bad start byte
        do_reset(); cs0 = 1'b1;
        send_hdr();
        send(8'hFE);
        chk(init_n0 == 1'b0, "R6 bad start byte halts", int'(init_n0), 0);

        // R11: recovery by program pulse
        do_reset();
        chk(init_n0 == 1'b1, "R11 program pulse clears halt", int'(init_n0), 1);
        full_load("R11");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule